// File: doc/BRIEF.md
# Conditional Execution Flag Unit

This block keeps the four arithmetic condition flags of a processor core: negative (N), zero (Z), carry (C) and overflow (V). For every instruction that starts executing, it compares the instruction's 4-bit condition field with the flags that are held at that moment. It then decides whether the instruction executes or is squashed. A squashed instruction must have no effect, so a flag write that comes with it is dropped. A flag write from an executing instruction takes effect on the next clock edge. As a result, the decision made in a cycle always uses the flags as they were before that cycle's write.

Code 1111 is not a condition. It opens a separate space of unconditional instructions, and the block reports it on its own output. A legacy-mode input changes how 1111 is handled: the code is then reported as undefined, and the instruction is squashed. The block also reports which kind of test the condition field selected. Instruction decode, the ALU, exceptions and coprocessors sit outside this block. They supply the strobes and the new flag values, and they consume the decision.

The design is purely combinational from the condition field to the decision outputs. Its only state is the flag register. That register is a small state element with two transitions: HOLD, when no qualifying write arrives, and LOAD, when an executing instruction requests a flag write. A synchronous reset takes it to the CLEAR value.

Top module: `cond_exec_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets all four flags to 0 on `flags_out`. `flags_out` packs the flags with N in bit 3, Z in bit 2, C in bit 1 and V in bit 0.
- R2: Condition code 1110 (always) executes whatever the flag values are.
- R3: The fourteen conditional codes pass as follows:
    - 0000: Z set. 0001: Z clear.
    - 0010: C set. 0011: C clear.
    - 0100: N set. 0101: N clear.
    - 0110: V set. 0111: V clear.
    - 1000: C set and Z clear. 1001: C clear or Z set.
    - 1010: N equals V. 1011: N differs from V.
    - 1100: Z clear and N equals V. 1101: Z set or N differs from V.
- R4: When an instruction starts and its condition fails, `squash` is 1 and `exec_go` is 0. Any flag write requested with it is ignored.
- R5: The flags load `flag_in` on the clock edge that follows a cycle with `exec_go` and `flag_wr` both high. Otherwise the flags hold their value.
- R6: With `legacy_mode` low, code 1111 gives `alt_space`=1 and `exec_go`=1, and `undef_code`=0.
- R7: With `legacy_mode` high, code 1111 gives `undef_code`=1 and `squash`=1, and `alt_space`=0 and `exec_go`=0.
- R8: When `instr_valid` and `exec_start` are not both high, `exec_go`, `squash`, `alt_space` and `undef_code` are all 0.
- R9: `cond_class` gives the kind of test the condition field selects:
    - 0: always (1110).
    - 1: equality (0000, 0001).
    - 2: single flag (0010 to 0111).
    - 3: unsigned magnitude (1000, 1001).
    - 4: signed magnitude (1010 to 1101).
    - 5: alternative space (1111).
- R10: The decision in a cycle uses the flags held before that cycle's write. A write becomes visible only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| legacy_mode | input | 1 | Treat code 1111 as undefined |
| instr_valid | input | 1 | Instruction present |
| exec_start | input | 1 | Instruction starts executing this cycle |
| cond_code | input | 4 | Condition field of the instruction |
| flag_wr | input | 1 | Instruction requests a flag update |
| flag_in | input | 4 | New flags {N,Z,C,V} from the ALU |
| exec_go | output | 1 | Instruction executes |
| squash | output | 1 | Instruction is suppressed |
| alt_space | output | 1 | Instruction is in the alternative unconditional space |
| undef_code | output | 1 | Code 1111 seen in legacy mode |
| cond_class | output | 3 | Kind of test selected (R9 encoding) |
| flags_out | output | 4 | Current flags {N,Z,C,V} |

## Verification
The assertions take for granted that `flag_wr` and `flag_in` matter only when an instruction starts. They also take for granted that the inputs settle between clock edges and never change at an edge. The stimulus meets both conditions by driving every input on the falling edge. It steps through every condition code under every flag value, with flag writes and the legacy setting both switched on and off. It then adds a seeded random run in which the valid and start strobes are toggled independently.

// File: rtl/ceu_pkg.sv
package ceu_pkg;
    localparam int FLAG_W  = 4;
    localparam int COND_W  = 4;
    localparam int CLASS_W = 3;
    localparam int FN = 3;
    localparam int FZ = 2;
    localparam int FC = 1;
    localparam int FV = 0;

    typedef enum logic [COND_W-1:0] {
        CC_EQ  = 4'h0, CC_NE = 4'h1, CC_HS = 4'h2, CC_LO = 4'h3,
        CC_MI  = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
        CC_HI  = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
        CC_GT  = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_ALT = 4'hF
    } cond_e;

    typedef enum logic [CLASS_W-1:0] {
        CLS_ALWAYS   = 3'd0,
        CLS_EQUAL    = 3'd1,
        CLS_FLAG     = 3'd2,
        CLS_UNSIGNED = 3'd3,
        CLS_SIGNED   = 3'd4,
        CLS_ALTSPACE = 3'd5
    } class_e;

    typedef enum logic [1:0] {
        FS_CLEAR = 2'd0,
        FS_HOLD  = 2'd1,
        FS_LOAD  = 2'd2
    } fstep_e;
endpackage

// File: rtl/ceu_cond_eval.sv
module ceu_cond_eval
    import ceu_pkg::*;
(
    input  logic [COND_W-1:0]  cond_i,
    input  logic [FLAG_W-1:0]  flags_i,
    output logic               pass_o,
    output logic               is_alt_o,
    output logic [CLASS_W-1:0] class_o
);
    logic n, z, c, v, nv_eq;
    cond_e  code;
    class_e cls;

    assign n     = flags_i[FN];
    assign z     = flags_i[FZ];
    assign c     = flags_i[FC];
    assign v     = flags_i[FV];
    assign nv_eq = (n == v);
    assign code  = cond_e'(cond_i);

    always_comb begin
        pass_o   = 1'b0;
        is_alt_o = 1'b0;
        cls      = CLS_ALWAYS;
        unique case (code)
            CC_EQ:  begin pass_o = z;             cls = CLS_EQUAL;    end
            CC_NE:  begin pass_o = !z;            cls = CLS_EQUAL;    end
            CC_HS:  begin pass_o = c;             cls = CLS_FLAG;     end
            CC_LO:  begin pass_o = !c;            cls = CLS_FLAG;     end
            CC_MI:  begin pass_o = n;             cls = CLS_FLAG;     end
            CC_PL:  begin pass_o = !n;            cls = CLS_FLAG;     end
            CC_VS:  begin pass_o = v;             cls = CLS_FLAG;     end
            CC_VC:  begin pass_o = !v;            cls = CLS_FLAG;     end
            CC_HI:  begin pass_o = c && !z;       cls = CLS_UNSIGNED; end
            CC_LS:  begin pass_o = !c || z;       cls = CLS_UNSIGNED; end
            CC_GE:  begin pass_o = nv_eq;         cls = CLS_SIGNED;   end
            CC_LT:  begin pass_o = !nv_eq;        cls = CLS_SIGNED;   end
            CC_GT:  begin pass_o = !z && nv_eq;   cls = CLS_SIGNED;   end
            CC_LE:  begin pass_o = z || !nv_eq;   cls = CLS_SIGNED;   end
            CC_AL:  begin pass_o = 1'b1;          cls = CLS_ALWAYS;   end
            CC_ALT: begin pass_o = 1'b1; is_alt_o = 1'b1; cls = CLS_ALTSPACE; end
            default: begin pass_o = 1'b0;         cls = CLS_ALWAYS;   end
        endcase
    end

    assign class_o = cls;

    // R2
    always_comb begin
        if (cond_i == 4'hE)
            always_pass_chk: assert (pass_o == 1'b1);
    end
endmodule

// File: rtl/ceu_decide.sv
module ceu_decide (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic pass_i,
    input  logic is_alt_i,
    input  logic legacy_i,
    output logic exec_o,
    output logic squash_o,
    output logic alt_o,
    output logic undef_o
);
    logic alt_hit, undef_hit;

    assign alt_hit   = is_alt_i && !legacy_i;
    assign undef_hit = is_alt_i && legacy_i;

    always_comb begin
        exec_o   = 1'b0;
        squash_o = 1'b0;
        alt_o    = 1'b0;
        undef_o  = 1'b0;
        if (start_i) begin
            alt_o    = alt_hit;
            undef_o  = undef_hit;
            exec_o   = pass_i && !undef_hit;
            squash_o = !(pass_i && !undef_hit);
        end
    end

    // R4
    decision_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |-> ($countones({exec_o, squash_o}) == 1));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |-> !(exec_o || squash_o || alt_o || undef_o));

    // R6
    alt_exec_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && is_alt_i && !legacy_i) |-> (alt_o && exec_o && !undef_o));

    // R7
    legacy_undef_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && is_alt_i && legacy_i) |-> (undef_o && squash_o && !alt_o && !exec_o));
endmodule

// File: rtl/ceu_flag_reg.sv
module ceu_flag_reg
    import ceu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [FLAG_W-1:0] flag_i,
    output logic [FLAG_W-1:0] flags_o
);
    fstep_e step;
    logic [FLAG_W-1:0] flags_q, flags_d;

    always_comb begin
        if (rst)         step = FS_CLEAR;
        else if (load_i) step = FS_LOAD;
        else             step = FS_HOLD;
    end

    always_comb begin
        flags_d = flags_q;
        unique case (step)
            FS_CLEAR: flags_d = '0;
            FS_LOAD:  flags_d = flag_i;
            FS_HOLD:  flags_d = flags_q;
            default:  flags_d = flags_q;
        endcase
    end

    always_ff @(posedge clk) begin
        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (flags_o == '0));
endmodule

// File: rtl/cond_exec_unit.sv
module cond_exec_unit
    import ceu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               legacy_mode,
    input  logic               instr_valid,
    input  logic               exec_start,
    input  logic [COND_W-1:0]  cond_code,
    input  logic               flag_wr,
    input  logic [FLAG_W-1:0]  flag_in,
    output logic               exec_go,
    output logic               squash,
    output logic               alt_space,
    output logic               undef_code,
    output logic [CLASS_W-1:0] cond_class,
    output logic [FLAG_W-1:0]  flags_out
);
    logic start, pass, is_alt, load;
    logic [FLAG_W-1:0] flags;

    assign start = instr_valid && exec_start;

    ceu_cond_eval u_eval (
        .cond_i   (cond_code),
        .flags_i  (flags),
        .pass_o   (pass),
        .is_alt_o (is_alt),
        .class_o  (cond_class)
    );

    ceu_decide u_decide (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .pass_i   (pass),
        .is_alt_i (is_alt),
        .legacy_i (legacy_mode),
        .exec_o   (exec_go),
        .squash_o (squash),
        .alt_o    (alt_space),
        .undef_o  (undef_code)
    );

    assign load = exec_go && flag_wr;

    ceu_flag_reg u_flags (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .flag_i  (flag_in),
        .flags_o (flags)
    );

    assign flags_out = flags;

    // R5 R10
    flag_load_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_go && flag_wr) |=> (flags_out == $past(flag_in)));

    // R4 R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(exec_go && flag_wr) |=> $stable(flags_out));
endmodule

// File: tb/test_cond_exec_unit.sv
module test_cond_exec_unit;
    logic clk = 1'b0;
    logic rst, legacy_mode, instr_valid, exec_start, flag_wr;
    logic [3:0] cond_code, flag_in;
    logic exec_go, squash, alt_space, undef_code;
    logic [2:0] cond_class;
    logic [3:0] flags_out;

    int checks = 0;
    int fails  = 0;
    logic [3:0] mflags;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cond_exec_unit i_cond_exec_unit (
        .clk(clk), .rst(rst), .legacy_mode(legacy_mode),
        .instr_valid(instr_valid), .exec_start(exec_start),
        .cond_code(cond_code), .flag_wr(flag_wr), .flag_in(flag_in),
        .exec_go(exec_go), .squash(squash), .alt_space(alt_space),
        .undef_code(undef_code), .cond_class(cond_class), .flags_out(flags_out)
    );

    function automatic logic ref_pass(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'h0: return z;
            4'h1: return !z;
            4'h2: return cy;
            4'h3: return !cy;
            4'h4: return n;
            4'h5: return !n;
            4'h6: return v;
            4'h7: return !v;
            4'h8: return cy & !z;
            4'h9: return !cy | z;
            4'hA: return n == v;
            4'hB: return n != v;
            4'hC: return !z & (n == v);
            4'hD: return z | (n != v);
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [2:0] ref_class(input logic [3:0] c);
        if (c == 4'hE) return 3'd0;
        if (c <= 4'h1) return 3'd1;
        if (c <= 4'h7) return 3'd2;
        if (c <= 4'h9) return 3'd3;
        if (c <= 4'hD) return 3'd4;
        return 3'd5;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic s, input logic [3:0] c,
                        input logic leg, input logic wr, input logic [3:0] nf);
        logic st, ex, sq, al, ud;
        @(negedge clk);
        instr_valid = v; exec_start = s; cond_code = c;
        legacy_mode = leg; flag_wr = wr; flag_in = nf;
        st = v & s;
        ud = st & (c == 4'hF) & leg;
        al = st & (c == 4'hF) & !leg;
        ex = st & !ud & ((c == 4'hF) ? 1'b1 : ref_pass(c, mflags));
        sq = st & !ex;
        #1;
        if (!st)
            chk({exec_go, squash, alt_space, undef_code} == 4'b0, "R8 idle outputs",
                {4'b0, exec_go, squash, alt_space, undef_code}, 8'h0);
        else if (c == 4'hE)
            chk(exec_go === 1'b1 && squash === 1'b0, "R2 always", {7'b0, exec_go}, 8'h1);
        else if (c == 4'hF && !leg)
            chk({exec_go, squash, alt_space, undef_code} == {ex, sq, al, ud}, "R6 alt space",
                {4'b0, exec_go, squash, alt_space, undef_code}, {4'b0, ex, sq, al, ud});
        else if (c == 4'hF)
            chk({exec_go, squash, alt_space, undef_code} == {ex, sq, al, ud}, "R7 legacy undef",
                {4'b0, exec_go, squash, alt_space, undef_code}, {4'b0, ex, sq, al, ud});
        else if (!ex)
            chk(exec_go === 1'b0 && squash === 1'b1, "R4 squash on fail",
                {6'b0, exec_go, squash}, 8'h1);
        else
            chk(exec_go === 1'b1 && squash === 1'b0, "R3 condition pass",
                {6'b0, exec_go, squash}, 8'h2);
        chk(cond_class == ref_class(c), "R9 class", {5'b0, cond_class}, {5'b0, ref_class(c)});
        @(posedge clk);
        #1;
        if (ex && wr) begin
            mflags = nf;
            chk(flags_out == mflags, "R5 R10 flag load", {4'b0, flags_out}, {4'b0, mflags});
        end else begin
            chk(flags_out == mflags, "R4 R5 flag hold", {4'b0, flags_out}, {4'b0, mflags});
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        rst = 1'b1; legacy_mode = 1'b0; instr_valid = 1'b0; exec_start = 1'b0;
        cond_code = 4'h0; flag_wr = 1'b0; flag_in = 4'h0;
        mflags = 4'h0;
        repeat (3) @(posedge clk);
        #1;
        chk(flags_out == 4'h0, "R1 reset clears flags", {4'b0, flags_out}, 8'h0);
        @(negedge clk);
        rst = 1'b0;

        // Exhaustive: every code under every flag value
        for (int f = 0; f < 16; f++) begin
            step(1'b1, 1'b1, 4'hE, 1'b0, 1'b1, 4'(f));
            for (int c = 0; c < 16; c++) begin
                step(1'b1, 1'b1, 4'(c), 1'b0, 1'b0, 4'h0);
                step(1'b1, 1'b1, 4'(c), 1'b1, 1'b0, 4'h0);
            end
        end

        // R10: update during a passing instruction, then a dependent test
        step(1'b1, 1'b1, 4'hE, 1'b0, 1'b1, 4'b0000);
        step(1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 4'b0100);
        step(1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 4'b0000);
        // R4: failing instruction tries to write
        step(1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 4'b1111);
        // R8: valid without start and start without valid carry writes
        step(1'b1, 1'b0, 4'hE, 1'b0, 1'b1, 4'b1010);
        step(1'b0, 1'b1, 4'hE, 1'b0, 1'b1, 4'b1010);
        // R7: legacy 1111 with a write request is dropped
        step(1'b1, 1'b1, 4'hF, 1'b1, 1'b1, 4'b1001);
        // R6: alternative-space instruction may write
        step(1'b1, 1'b1, 4'hF, 1'b0, 1'b1, 4'b1001);

        // Constrained random run
        for (int i = 0; i < 2000; i++) begin
            step(($urandom % 8) != 0, ($urandom % 8) != 0, 4'($urandom),
                 ($urandom % 4) == 0, ($urandom % 2) == 0, 4'($urandom));
        end

        // R1: reset mid-run after flags were set
        step(1'b1, 1'b1, 4'hE, 1'b0, 1'b1, 4'b1111);
        @(negedge clk);
        rst = 1'b1; instr_valid = 1'b0; exec_start = 1'b0;
        @(posedge clk);
        #1;
        mflags = 4'h0;
        chk(flags_out == 4'h0, "R1 reset clears flags", {4'b0, flags_out}, 8'h0);
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule